// File: doc/BRIEF.md
# Flash Row Program Control Registers

This block is the register front end of an on-chip flash controller. Software reaches it over a simple 32-bit write/read register bus. It holds a control word, a key port, a target row address and a source buffer address. The control word carries an operation selector, a write-enable bit, an error flag, a low-voltage settling bit and a start/busy bit. Besides its own address, the control word has two alias addresses: one clears the bits given in a mask and the other sets them.

A program operation starts only when a write sets the start bit and that write comes directly after two key-port writes in a fixed order. Once accepted, the block holds the busy bit for a programmable number of clock cycles. The busy bit then clears by itself, and software polls it to find out when the operation has finished. If an armed start asks for an operation that cannot run, the block sets the error flag instead of starting. The flash array, the data movement from the source buffer and the analog timing are not modelled.

Top module: `flash_ctl_regif`

## Requirements
- R1: After reset, the control word, row address and source address all read 0, and the unlock sequence is idle.
- R2: Offset 0x20 holds the row address and offset 0x40 holds the source address, each 32 bits and read back unchanged. A plain write to offset 0x00 loads write-enable (bit 14) and the operation selector (bits 3:0). The key port at 0x10 and any unmapped offset read 0.
- R3: A write to 0x04 clears only the bits of the control word that are 1 in the written mask. A write to 0x08 sets only those bits. Both aliases read the same value as 0x00.
- R4: After a plain write to 0x00 with bit 15 at 0, bit 11 reads 1 for LVD_CYCLES cycles and then reads 0.
- R5: The block arms after a key write of 0xAA996655 to 0x10 followed by a key write of 0x556699AA. If the very next bus write sets bit 15 (through 0x00 or 0x08) with write-enable 1 and selector 4'b0011, bit 15 and flash_busy go high.
- R6: Once started, bit 15 stays high for exactly PROG_CYCLES clock cycles and then clears by itself.
- R7: A start request is ignored (busy and error both stay 0) in each of these cases: no unlock was done, the keys came in the wrong order, a key value was wrong, or some other write came between the key pair and the start.
- R8: Key writes made while bit 11 reads 1 do not advance the unlock sequence.
- R9: An armed start with write-enable 0, or with a selector other than 4'b0011, sets the error bit (bit 13) and runs no operation.
- R10: While busy, writes to the row and source address registers are ignored. Reads still return the held values.
- R11: The error bit clears only when bit 13 is written to the clear alias. A plain write with bit 13 set does not set it.
- R12: While busy, a clear-alias write of bit 15 does not end the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Write strobe for the register bus |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| flash_busy | output | 1 | High while a program operation runs |

## Verification
The bench targets the unlock window. It tries wrong key order, a wrong second key, an unrelated write between the key pair and the start, and key writes made during the settling window. A design that armed too loosely would start an operation in one of these cases, and the busy bit would show it. The bench times the busy interval to the exact cycle, so a counter that is off by one fails at one edge or the other. It also checks that the error path is taken for a disabled or unsupported start and that the aliases touch only the masked bits. A design that merged the start write wrongly, or cleared the whole word, would read back the wrong control value.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;

  localparam logic [7:0] OFF_CTRL = 8'h00;
  localparam logic [7:0] OFF_CLR  = 8'h04;
  localparam logic [7:0] OFF_SET  = 8'h08;
  localparam logic [7:0] OFF_KEY  = 8'h10;
  localparam logic [7:0] OFF_ROW  = 8'h20;
  localparam logic [7:0] OFF_SRC  = 8'h40;

  localparam int BIT_GO  = 15;
  localparam int BIT_WEN = 14;
  localparam int BIT_ERR = 13;
  localparam int BIT_LVD = 11;

  localparam logic [31:0] KEY_FIRST  = 32'hAA99_6655;
  localparam logic [31:0] KEY_SECOND = 32'h5566_99AA;
  localparam logic [3:0]  OP_ROW_PROG = 4'b0011;

  typedef enum logic [1:0] {
    UL_IDLE  = 2'd0,
    UL_HALF  = 2'd1,
    UL_ARMED = 2'd2
  } unlock_e;

  typedef struct packed {
    logic       wen;
    logic [3:0] op;
  } cfg_t;

  function automatic cfg_t cfg_from_word(input logic [31:0] w);
    cfg_t c;
    c.wen = w[BIT_WEN];
    c.op  = w[3:0];
    return c;
  endfunction

  function automatic cfg_t cfg_clear(input cfg_t c, input logic [31:0] m);
    cfg_t r;
    r.wen = c.wen & ~m[BIT_WEN];
    r.op  = c.op  & ~m[3:0];
    return r;
  endfunction

  function automatic cfg_t cfg_set(input cfg_t c, input logic [31:0] m);
    cfg_t r;
    r.wen = c.wen | m[BIT_WEN];
    r.op  = c.op  | m[3:0];
    return r;
  endfunction

  function automatic logic op_runnable(input cfg_t c);
    return c.wen && (c.op == OP_ROW_PROG);
  endfunction

  function automatic logic [31:0] ctrl_word(input logic go, input cfg_t c,
                                            input logic err, input logic lvd);
    logic [31:0] w;
    w = '0;
    w[BIT_GO]  = go;
    w[BIT_WEN] = c.wen;
    w[BIT_ERR] = err;
    w[BIT_LVD] = lvd;
    w[3:0]     = c.op;
    return w;
  endfunction

endpackage

// File: rtl/flash_unlock_fsm.sv
module flash_unlock_fsm
  import flash_ctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_any,
  input  logic        wr_key,
  input  logic [31:0] wr_data,
  input  logic        lvd_active,
  output logic        armed
);

  unlock_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (wr_any) begin
      if (wr_key && !lvd_active && wr_data == KEY_FIRST)
        state_d = UL_HALF;
      else if (wr_key && !lvd_active && state_q == UL_HALF && wr_data == KEY_SECOND)
        state_d = UL_ARMED;
      else
        state_d = UL_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= UL_IDLE;
    else        state_q <= state_d;
  end

  assign armed = (state_q == UL_ARMED);

  AST_ARM_NEEDS_SECOND_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(wr_key && wr_data == KEY_SECOND)); // R5

  AST_LVD_BLOCKS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && lvd_active) |=> !armed); // R8

endmodule

// File: rtl/flash_settle_timer.sv
module flash_settle_timer #(
  parameter int CYCLES = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger,
  output logic active
);

  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (trigger)       cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign active = (cnt_q != '0);

  AST_SETTLE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |=> active); // R4

  AST_SETTLE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(CYCLES)); // R4

endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
  parameter int CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  output logic busy,
  output logic done
);

  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (launch && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy); // R6

  AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R6

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q < CW'(CYCLES))); // R6

endmodule

// File: rtl/flash_ctl_regif.sv
module flash_ctl_regif
  import flash_ctl_pkg::*;
#(
  parameter int PROG_CYCLES = 40,
  parameter int LVD_CYCLES  = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        flash_busy
);

  logic wr_ctrl, wr_clr, wr_set, wr_key, wr_row, wr_src;
  logic start_req, start_eval, start_go, start_bad;
  logic armed, busy, op_done, lvd_active, lvd_trigger;
  cfg_t cfg_q, cfg_d;
  logic err_q;
  logic [31:0] row_q, src_q;

  assign wr_ctrl = reg_we && (reg_addr == OFF_CTRL);
  assign wr_clr  = reg_we && (reg_addr == OFF_CLR);
  assign wr_set  = reg_we && (reg_addr == OFF_SET);
  assign wr_key  = reg_we && (reg_addr == OFF_KEY);
  assign wr_row  = reg_we && (reg_addr == OFF_ROW);
  assign wr_src  = reg_we && (reg_addr == OFF_SRC);

  always_comb begin
    cfg_d = cfg_q;
    if (wr_ctrl)     cfg_d = cfg_from_word(reg_wdata);
    else if (wr_clr) cfg_d = cfg_clear(cfg_q, reg_wdata);
    else if (wr_set) cfg_d = cfg_set(cfg_q, reg_wdata);
  end

  assign start_req   = (wr_ctrl || wr_set) && reg_wdata[BIT_GO];
  assign start_eval  = start_req && armed && !busy;
  assign start_go    = start_eval && op_runnable(cfg_d);
  assign start_bad   = start_eval && !op_runnable(cfg_d);
  assign lvd_trigger = wr_ctrl && !reg_wdata[BIT_GO];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      err_q <= 1'b0;
      row_q <= '0;
      src_q <= '0;
    end else begin
      cfg_q <= cfg_d;
      if (start_bad)                         err_q <= 1'b1;
      else if (wr_clr && reg_wdata[BIT_ERR]) err_q <= 1'b0;
      if (wr_row && !busy) row_q <= reg_wdata;
      if (wr_src && !busy) src_q <= reg_wdata;
    end
  end

  flash_unlock_fsm u_unlock (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_any     (reg_we),
    .wr_key     (wr_key),
    .wr_data    (reg_wdata),
    .lvd_active (lvd_active),
    .armed      (armed)
  );

  flash_settle_timer #(.CYCLES(LVD_CYCLES)) u_settle (
    .clk     (clk),
    .rst_n   (rst_n),
    .trigger (lvd_trigger),
    .active  (lvd_active)
  );

  flash_op_timer #(.CYCLES(PROG_CYCLES)) u_optimer (
    .clk    (clk),
    .rst_n  (rst_n),
    .launch (start_go),
    .busy   (busy),
    .done   (op_done)
  );

  always_comb begin
    case (reg_addr)
      OFF_CTRL, OFF_CLR, OFF_SET: reg_rdata = ctrl_word(busy, cfg_q, err_q, lvd_active);
      OFF_ROW:                    reg_rdata = row_q;
      OFF_SRC:                    reg_rdata = src_q;
      default:                    reg_rdata = '0;
    endcase
  end

  assign flash_busy = busy;

  AST_GO_STARTS_OP: assert property (@(posedge clk) disable iff (!rst_n)
    start_go |=> busy); // R5

  AST_UNARMED_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !armed && !busy) |=> !busy); // R7

  AST_BAD_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    start_bad |=> (err_q && !busy)); // R9

  AST_ROW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_row) |=> $stable(row_q)); // R10

  AST_SRC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_src) |=> $stable(src_q)); // R10

  AST_ERR_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_q && !start_bad) |=> !err_q); // R11

  AST_CLR_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !op_done && wr_clr) |=> busy); // R12

endmodule

// File: tb/sim_flash_ctl_regif.sv
module sim_flash_ctl_regif;

  localparam int PROG = 20;
  localparam int LVD  = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        flash_busy;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  flash_ctl_regif #(.PROG_CYCLES(PROG), .LVD_CYCLES(LVD)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .flash_busy (flash_busy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic settle();
    repeat (LVD + 2) @(negedge clk);
  endtask

  task automatic unlock();
    wr(8'h10, 32'hAA99_6655);
    wr(8'h10, 32'h5566_99AA);
  endtask

  task automatic wait_idle();
    repeat (PROG + 2) @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    rd(8'h00, v); check("R1 ctrl", v, 32'h0);
    rd(8'h20, v); check("R1 row", v, 32'h0);
    rd(8'h40, v); check("R1 src", v, 32'h0);
  endtask

  task automatic t_map();
    logic [31:0] v;
    wr(8'h20, 32'h1234_5678);
    wr(8'h40, 32'h9ABC_DEF0);
    rd(8'h20, v); check("R2 row", v, 32'h1234_5678);
    rd(8'h40, v); check("R2 src", v, 32'h9ABC_DEF0);
    rd(8'h10, v); check("R2 key reads 0", v, 32'h0);
    rd(8'h30, v); check("R2 unmapped", v, 32'h0);
    wr(8'h00, 32'h0000_4003);
    settle();
    rd(8'h00, v); check("R2 ctrl", v, 32'h0000_4003);
  endtask

  task automatic t_alias();
    logic [31:0] v;
    wr(8'h00, 32'h0000_0001);
    settle();
    wr(8'h08, 32'h0000_4002);
    rd(8'h00, v); check("R3 set alias", v, 32'h0000_4003);
    wr(8'h04, 32'h0000_0001);
    rd(8'h00, v); check("R3 clear alias", v, 32'h0000_4002);
    rd(8'h04, v); check("R3 alias reads ctrl", v, 32'h0000_4002);
  endtask

  task automatic t_lvd();
    logic [31:0] v;
    wr(8'h00, 32'h0000_4003);
    rd(8'h00, v); check("R4 lvd set", v & 32'h800, 32'h800);
    repeat (LVD - 2) @(negedge clk);
    rd(8'h00, v); check("R4 lvd still set", v & 32'h800, 32'h800);
    repeat (2) @(negedge clk);
    rd(8'h00, v); check("R4 lvd cleared", v & 32'h800, 32'h0);
  endtask

  task automatic t_program();
    logic [31:0] v;
    wr(8'h20, 32'h0000_1000);
    wr(8'h00, 32'h0000_4003);
    settle();
    unlock();
    wr(8'h08, 32'h0000_8000);
    rd(8'h00, v); check("R5 busy after start", v, 32'h0000_C003);
    check("R5 flash_busy", {31'h0, flash_busy}, 32'h1);
    wr(8'h20, 32'h0000_DEAD);
    rd(8'h20, v); check("R10 row frozen", v, 32'h0000_1000);
    wr(8'h04, 32'h0000_8000);
    rd(8'h00, v); check("R12 clear keeps busy", v & 32'h8000, 32'h8000);
    repeat (PROG - 5) @(negedge clk);
    rd(8'h00, v); check("R6 last busy cycle", v & 32'h8000, 32'h8000);
    @(negedge clk);
    rd(8'h00, v); check("R6 busy cleared", v, 32'h0000_4003);
    wr(8'h20, 32'h0000_2000);
    rd(8'h20, v); check("R10 row writable after", v, 32'h0000_2000);
    wr(8'h04, 32'h0000_4000);
    rd(8'h00, v); check("R3 wen removed", v, 32'h0000_0003);
  endtask

  task automatic t_bad_sequences();
    logic [31:0] v;
    wr(8'h00, 32'h0000_4003); settle();
    wr(8'h00, 32'h0000_C003);
    rd(8'h00, v); check("R7 no unlock", v & 32'hA000, 32'h0);
    wr(8'h10, 32'h5566_99AA); wr(8'h10, 32'hAA99_6655);
    wr(8'h00, 32'h0000_C003);
    rd(8'h00, v); check("R7 wrong order", v & 32'hA000, 32'h0);
    wr(8'h10, 32'hAA99_6655); wr(8'h10, 32'h5566_99AB);
    wr(8'h08, 32'h0000_8000);
    rd(8'h00, v); check("R7 wrong key", v & 32'hA000, 32'h0);
    unlock();
    wr(8'h20, 32'h0000_3000);
    wr(8'h08, 32'h0000_8000);
    rd(8'h00, v); check("R7 intervening write", v & 32'hA000, 32'h0);
  endtask

  task automatic t_lvd_blocks();
    logic [31:0] v;
    wr(8'h00, 32'h0000_4003);
    unlock();
    wr(8'h08, 32'h0000_8000);
    rd(8'h00, v); check("R8 unlock during lvd", v & 32'hA000, 32'h0);
    settle();
  endtask

  task automatic t_reject();
    logic [31:0] v;
    wr(8'h00, 32'h0000_0003); settle();
    unlock();
    wr(8'h08, 32'h0000_8000);
    rd(8'h00, v); check("R9 wen off", v, 32'h0000_2003);
    wr(8'h00, 32'h0000_6003);
    rd(8'h00, v); check("R11 plain write keeps err", v & 32'h2000, 32'h2000);
    wr(8'h04, 32'h0000_2000);
    rd(8'h00, v); check("R11 clear err", v & 32'h2000, 32'h0);
    wr(8'h00, 32'h0000_6003);
    rd(8'h00, v); check("R11 plain write no set", v & 32'h2000, 32'h0);
    wr(8'h00, 32'h0000_4005); settle();
    unlock();
    wr(8'h00, 32'h0000_C005);
    rd(8'h00, v); check("R9 bad op", v, 32'h0000_6005);
    check("R9 no busy", {31'h0, flash_busy}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_map();
    t_alias();
    t_lvd();
    t_program();
    wait_idle();
    t_bad_sequences();
    t_lvd_blocks();
    t_reject();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule